// File: doc/BRIEF.md
# Sensor Start-Up Phase Sequencer

This block is the power-up controller for a sensor's serial interface. Once reset is released it walks through five phases in a fixed order. Phase 1 is a silent settling period of programmable length. Phase 2 sends device data. Phase 3 is self-test. Phase 4 is fast auto-zero initialization. Phase 5 is normal run time. Each of phases 2 to 4 ends when its own completion flag is raised. Phase 5 is the last phase and the machine stays in it.

The surrounding interface logic decodes incoming sync pulses into a one-cycle strobe. For each strobe accepted in phases 2 to 5, the sequencer answers with one formatted data word. During phase 2 a 2-bit mode code selects the device-data source. Eight-bit values are placed at the low or high end of the 10-bit frame, depending on a frame-width enable. An error flag raised for the current phase sends the machine to a terminal fault state. In that state every sync pulse returns a fixed error code until the next reset. A parity-monitor enable is set when phase 2 completes and stays set.

Top module: `startup_phase_seq`

## Requirements
- R1: While reset is asserted and right after it, `phase` is 1 (phase values are 1 to 5, and 7 means fault). In that state `tx_en`, `tx_word`, `par_mon_en` and `fault` are all 0.
- R2: After reset is released, `phase` stays 1 for exactly INIT_CYCLES rising clock edges and reads 2 after the INIT_CYCLES-th edge.
- R3: While `phase` is 1, sync strobes produce no `tx_en`, and every `step_done` and `phase_err` bit is ignored.
- R4: Phases 2, 3 and 4 advance by one phase on the edge where `step_done[phase-2]` is 1. Any other `step_done` bit has no effect. Phase 5 is never left through `step_done`.
- R5: In phases 2 to 5, `phase_err[phase-2]` = 1 moves the machine to the fault state on the next edge (`phase` = 7, `fault` = 1). This takes priority over a `step_done` raised in the same cycle. Error bits that belong to other phases are ignored.
- R6: The fault state is left only by reset. In the fault state every sync strobe returns ERR_CODE.
- R7: A sync strobe sampled in phases 2 to 5 or in fault produces `tx_en` = 1 for one cycle after that edge, with the new word on `tx_word`. Without a strobe, `tx_en` is 0 and `tx_word` holds its previous value.
- R8: In phase 2, with `dev_mode` 0, 1 or 2, the byte sent is `dev_byte`, `range_byte` or `code_byte` in that order. When `wide_en` is 1 the byte occupies bits 9:2 and bits 1:0 are 0. When `wide_en` is 0 the byte occupies bits 7:0 and bits 9:8 are 0.
- R9: In phase 2 with `dev_mode` 3, `tx_word` is `code_word` in full, whatever the value of `wide_en`.
- R10: In phases 3 to 5, `tx_word` is `live_word` when `wide_en` is 1. When `wide_en` is 0 it is `live_word[9:2]` in bits 7:0, with bits 9:8 at 0.
- R11: `par_mon_en` rises on the edge where phase 2 completes through `step_done[0]`. It then stays 1, including in a later fault state, until reset. It stays 0 if phase 2 ends in a fault.
- R12: Asserting reset in any phase returns `phase` to 1 and restarts the full phase 1 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_stb | input | 1 | One-cycle strobe for each decoded sync pulse |
| step_done | input | 3 | Completion flags for phases 2, 3, 4 (bit 0 = phase 2) |
| phase_err | input | 4 | Error flags for phases 2 to 5 (bit 0 = phase 2) |
| dev_mode | input | 2 | Phase 2 data mode: 0 standard, 1 range only, 2 coded 8-bit, 3 coded 10-bit |
| wide_en | input | 1 | 1 selects the 10-bit frame layout |
| dev_byte | input | 8 | Standard device-data byte |
| range_byte | input | 8 | Range-only byte |
| code_byte | input | 8 | Coded 8-bit device-data byte |
| code_word | input | 10 | Coded 10-bit device-data word |
| live_word | input | 10 | Sensor word for phases 3 to 5 |
| phase | output | 3 | Current phase, 1 to 5, 7 in fault |
| tx_en | output | 1 | A response word is valid this cycle |
| tx_word | output | 10 | Response word |
| par_mon_en | output | 1 | Parity monitoring enabled |
| fault | output | 1 | Terminal error state |

## Verification
A wrong phase register appears on `phase` in the cycle after the faulty edge. A wrong phase also changes the source or layout of the next response word, so the very next sync strobe exposes it on `tx_word`. A timer that is off by one moves the first phase 2 reading by one cycle. A parity or fault flag that is lost or set by mistake shows on its port straight away and stays wrong, because both flags are sticky. The reference model is compared with every output on every clock, so any difference is reported in the cycle in which it first appears.

// File: rtl/sps_pkg.sv
package sps_pkg;
   typedef enum logic [2:0] {
      PH_INIT  = 3'd1,
      PH_DEV   = 3'd2,
      PH_TEST  = 3'd3,
      PH_AZ    = 3'd4,
      PH_RUN   = 3'd5,
      PH_FAULT = 3'd7
   } phase_e;

   typedef enum logic [1:0] {
      MD_STD    = 2'd0,
      MD_RANGE  = 2'd1,
      MD_CODE8  = 2'd2,
      MD_CODE10 = 2'd3
   } devmode_e;

   localparam int unsigned NUM_STEP = 3;
   localparam int unsigned NUM_ERR  = 4;
endpackage

// File: rtl/sps_init_timer.sv
module sps_init_timer #(
   parameter int unsigned INIT_CYCLES = 5000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   generate
      if (INIT_CYCLES < 1) begin : g_bad
         $error("INIT_CYCLES must be at least 1");
      end
      if (INIT_CYCLES == 1) begin : g_single
         assign expired = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(INIT_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (run && cnt_q != LAST) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign expired = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sps_phase_ctl.sv
module sps_phase_ctl
   import sps_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                init_expired,
   input  logic [NUM_STEP-1:0] step_done,
   input  logic [NUM_ERR-1:0]  phase_err,
   output phase_e              phase_q,
   output logic                par_q
);
   phase_e phase_d;
   logic   par_set;

   always_comb begin
      phase_d = phase_q;
      par_set = 1'b0;
      unique case (phase_q)
         PH_INIT: begin
            if (init_expired) phase_d = PH_DEV;
         end
         PH_DEV: begin
            if (phase_err[0]) begin
               phase_d = PH_FAULT;
            end else if (step_done[0]) begin
               phase_d = PH_TEST;
               par_set = 1'b1;
            end
         end
         PH_TEST: begin
            if (phase_err[1])      phase_d = PH_FAULT;
            else if (step_done[1]) phase_d = PH_AZ;
         end
         PH_AZ: begin
            if (phase_err[2])      phase_d = PH_FAULT;
            else if (step_done[2]) phase_d = PH_RUN;
         end
         PH_RUN: begin
            if (phase_err[3]) phase_d = PH_FAULT;
         end
         default: phase_d = PH_FAULT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_INIT;
         par_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (par_set) par_q <= 1'b1;
      end
   end
endmodule

// File: rtl/sps_word_fmt.sv
module sps_word_fmt
   import sps_pkg::*;
#(
   parameter int unsigned WORD_W   = 10,
   parameter int unsigned BYTE_W   = 8,
   parameter logic [WORD_W-1:0] ERR_CODE = '0
) (
   input  phase_e            phase,
   input  logic [1:0]        dev_mode,
   input  logic              wide_en,
   input  logic [BYTE_W-1:0] dev_byte,
   input  logic [BYTE_W-1:0] range_byte,
   input  logic [BYTE_W-1:0] code_byte,
   input  logic [WORD_W-1:0] code_word,
   input  logic [WORD_W-1:0] live_word,
   output logic [WORD_W-1:0] word
);
   localparam int unsigned PAD = WORD_W - BYTE_W;

   generate
      if (WORD_W <= BYTE_W) begin : g_bad
         $error("WORD_W must exceed BYTE_W");
      end
   endgenerate

   logic [BYTE_W-1:0] sel_byte;
   logic [WORD_W-1:0] byte_frame;
   logic [WORD_W-1:0] live_frame;

   always_comb begin
      unique case (devmode_e'(dev_mode))
         MD_STD:   sel_byte = dev_byte;
         MD_RANGE: sel_byte = range_byte;
         default:  sel_byte = code_byte;
      endcase
      byte_frame = wide_en ? {sel_byte, {PAD{1'b0}}} : {{PAD{1'b0}}, sel_byte};
      live_frame = wide_en ? live_word : {{PAD{1'b0}}, live_word[WORD_W-1:PAD]};
   end

   always_comb begin
      if (phase == PH_FAULT) begin
         word = ERR_CODE;
      end else if (phase == PH_DEV) begin
         word = (devmode_e'(dev_mode) == MD_CODE10) ? code_word : byte_frame;
      end else begin
         word = live_frame;
      end
   end
endmodule

// File: rtl/startup_phase_seq.sv
module startup_phase_seq
   import sps_pkg::*;
#(
   parameter int unsigned INIT_CYCLES = 5000000,
   parameter int unsigned WORD_W      = 10,
   parameter int unsigned BYTE_W      = 8,
   parameter logic [WORD_W-1:0] ERR_CODE = 10'h2A5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_stb,
   input  logic [2:0]        step_done,
   input  logic [3:0]        phase_err,
   input  logic [1:0]        dev_mode,
   input  logic              wide_en,
   input  logic [BYTE_W-1:0] dev_byte,
   input  logic [BYTE_W-1:0] range_byte,
   input  logic [BYTE_W-1:0] code_byte,
   input  logic [WORD_W-1:0] code_word,
   input  logic [WORD_W-1:0] live_word,
   output logic [2:0]        phase,
   output logic              tx_en,
   output logic [WORD_W-1:0] tx_word,
   output logic              par_mon_en,
   output logic              fault
);
   phase_e            phase_q;
   logic              init_expired;
   logic              par_q;
   logic [WORD_W-1:0] fmt_word;
   logic              accept;
   logic              tx_en_q;
   logic [WORD_W-1:0] tx_word_q;

   sps_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (phase_q == PH_INIT),
      .expired (init_expired)
   );

   sps_phase_ctl u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .init_expired (init_expired),
      .step_done    (step_done),
      .phase_err    (phase_err),
      .phase_q      (phase_q),
      .par_q        (par_q)
   );

   sps_word_fmt #(
      .WORD_W   (WORD_W),
      .BYTE_W   (BYTE_W),
      .ERR_CODE (ERR_CODE)
   ) u_fmt (
      .phase      (phase_q),
      .dev_mode   (dev_mode),
      .wide_en    (wide_en),
      .dev_byte   (dev_byte),
      .range_byte (range_byte),
      .code_byte  (code_byte),
      .code_word  (code_word),
      .live_word  (live_word),
      .word       (fmt_word)
   );

   assign accept = sync_stb && (phase_q != PH_INIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en_q   <= 1'b0;
         tx_word_q <= '0;
      end else begin
         tx_en_q <= accept;
         if (accept) tx_word_q <= fmt_word;
      end
   end

   assign phase      = phase_q;
   assign tx_en      = tx_en_q;
   assign tx_word    = tx_word_q;
   assign par_mon_en = par_q;
   assign fault      = (phase_q == PH_FAULT);
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
   parameter int unsigned WORD_W = 10,
   parameter logic [WORD_W-1:0] ERR_CODE = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_stb,
   input logic [2:0]        phase,
   input logic              tx_en,
   input logic [WORD_W-1:0] tx_word,
   input logic              par_mon_en,
   input logic              fault
);
   AST_INIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd1) |=> !tx_en); // R3

   AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase) && phase != 3'd7) |-> (phase == $past(phase) + 3'd1)); // R4

   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault); // R6

   AST_FAULT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $past(fault)) |-> (tx_word == ERR_CODE)); // R6

   AST_TX_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> $past(sync_stb)); // R7

   AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      par_mon_en |=> par_mon_en); // R11

   AST_PAR_AFTER_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      par_mon_en |-> (phase != 3'd1 && phase != 3'd2)); // R11
endmodule

bind startup_phase_seq sps_checker #(.WORD_W(WORD_W), .ERR_CODE(ERR_CODE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sync_stb   (sync_stb),
   .phase      (phase),
   .tx_en      (tx_en),
   .tx_word    (tx_word),
   .par_mon_en (par_mon_en),
   .fault      (fault)
);

// File: tb/startup_phase_seq_bench.sv
`timescale 1ns/1ps
module startup_phase_seq_bench;
   localparam int INIT = 20;
   localparam logic [9:0] ERRC = 10'h2A5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_stb = 1'b0;
   logic [2:0] step_done = '0;
   logic [3:0] phase_err = '0;
   logic [1:0] dev_mode = '0;
   logic       wide_en = 1'b0;
   logic [7:0] dev_byte = 8'hA7, range_byte = 8'h3C, code_byte = 8'hE1;
   logic [9:0] code_word = 10'h1B6, live_word = 10'h2CD;
   logic [2:0] phase;
   logic       tx_en, par_mon_en, fault;
   logic [9:0] tx_word;

   int checks = 0, errors = 0;
   string cur_req = "R1";

   int m_ph, m_cnt, m_par, m_tx, m_word;

   always #10 clk = ~clk;

   startup_phase_seq #(.INIT_CYCLES(INIT), .ERR_CODE(ERRC)) u_startup_phase_seq (
      .clk(clk), .rst_n(rst_n), .sync_stb(sync_stb), .step_done(step_done),
      .phase_err(phase_err), .dev_mode(dev_mode), .wide_en(wide_en),
      .dev_byte(dev_byte), .range_byte(range_byte), .code_byte(code_byte),
      .code_word(code_word), .live_word(live_word), .phase(phase),
      .tx_en(tx_en), .tx_word(tx_word), .par_mon_en(par_mon_en), .fault(fault)
   );

   function automatic int exp_word(int p);
      int b;
      if (p == 7) return int'(ERRC);
      if (p == 2) begin
         if (dev_mode == 2'd3) return int'(code_word);
         b = (dev_mode == 2'd0) ? int'(dev_byte) : (dev_mode == 2'd1) ? int'(range_byte) : int'(code_byte);
         return wide_en ? b * 4 : b;
      end
      return wide_en ? int'(live_word) : int'(live_word) / 4;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 1; m_cnt = 0; m_par = 0; m_tx = 0; m_word = 0;
      end else begin
         int p;
         p = m_ph;
         m_tx = 0;
         if (sync_stb && p != 1) begin
            m_tx = 1;
            m_word = exp_word(p);
         end
         if (p == 1) begin
            m_cnt++;
            if (m_cnt == INIT) m_ph = 2;
         end else if (p >= 2 && p <= 5) begin
            if (phase_err[p-2]) m_ph = 7;
            else if (p <= 4 && step_done[p-2]) begin
               m_ph = p + 1;
               if (p == 2) m_par = 1;
            end
         end
      end
   end

   task automatic chk(string req, string what, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
      end
   endtask

   always @(negedge clk) begin
      chk(cur_req, "phase", int'(phase), m_ph);
      chk(cur_req, "tx_en", int'(tx_en), m_tx);
      chk(cur_req, "tx_word", int'(tx_word), m_word);
      chk(cur_req, "par_mon_en", int'(par_mon_en), m_par);
      chk(cur_req, "fault", int'(fault), (m_ph == 7) ? 1 : 0);
   end

   task automatic cyc(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic pulse_sync;
      sync_stb = 1'b1; cyc(); sync_stb = 1'b0; cyc();
   endtask

   task automatic release_reset;
      rst_n = 1'b0; cyc(2); rst_n = 1'b1;
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      cyc(2);
      chk("R1", "phase in reset", int'(phase), 1);
      chk("R1", "tx_en in reset", int'(tx_en), 0);
      chk("R1", "par in reset", int'(par_mon_en), 0);
      // R2 / R3: phase 1 length, deaf to sync, done and error
      cur_req = "R3";
      rst_n = 1'b1; sync_stb = 1'b1; step_done = 3'b111; phase_err = 4'hF;
      repeat (INIT - 1) @(negedge clk);
      chk("R2", "phase before expiry", int'(phase), 1);
      chk("R3", "no fault in phase 1", int'(fault), 0);
      @(negedge clk);
      chk("R2", "phase at expiry", int'(phase), 2);
      chk("R3", "no tx in phase 1", int'(tx_en), 0);
      #1; sync_stb = 1'b0; step_done = '0; phase_err = '0;
      cyc();
      // R8 / R9: phase 2 formats
      for (int w = 0; w < 2; w++) begin
         for (int m = 0; m < 4; m++) begin
            cur_req = (m == 3) ? "R9" : "R8";
            wide_en = w[0]; dev_mode = m[1:0];
            pulse_sync();
         end
      end
      // R7: hold without sync, back-to-back strobes
      cur_req = "R7";
      dev_mode = 2'd0; wide_en = 1'b1;
      sync_stb = 1'b1; cyc(3); sync_stb = 1'b0; dev_byte = 8'h55; cyc(3);
      // R4 / R5: other phases' flags ignored in phase 2
      cur_req = "R4";
      step_done = 3'b110; phase_err = 4'b1110; cyc(2);
      step_done = '0; phase_err = '0;
      chk("R4", "phase 2 held", int'(phase), 2);
      // R11: leave phase 2
      cur_req = "R11";
      step_done = 3'b001; cyc(); step_done = '0; cyc();
      chk("R11", "par set", int'(par_mon_en), 1);
      // R10: live data in phases 3..5
      cur_req = "R10";
      wide_en = 1'b0; pulse_sync();
      wide_en = 1'b1; live_word = 10'h3F1; pulse_sync();
      cur_req = "R4";
      step_done = 3'b010; cyc(); step_done = '0;
      cur_req = "R10";
      wide_en = 1'b0; pulse_sync();
      cur_req = "R4";
      step_done = 3'b100; cyc(); step_done = 3'b111; cyc(3); step_done = '0;
      chk("R4", "phase 5 terminal", int'(phase), 5);
      cur_req = "R10";
      live_word = 10'h0A3; wide_en = 1'b1; pulse_sync();
      // R5 / R6: fault in phase 5, stickiness, error code
      cur_req = "R5";
      phase_err = 4'b1000; cyc(); phase_err = '0; cyc();
      chk("R5", "fault entered", int'(phase), 7);
      cur_req = "R6";
      step_done = 3'b111; pulse_sync(); pulse_sync(); step_done = '0;
      chk("R6", "fault word", int'(tx_word), int'(ERRC));
      chk("R11", "par kept in fault", int'(par_mon_en), 1);
      // R12: reset mid-sequence restarts phase 1 timing
      cur_req = "R12";
      release_reset();
      chk("R12", "phase after reset", int'(phase), 1);
      cyc(INIT + 2);
      step_done = 3'b001; cyc(); step_done = '0; cyc(2);
      chk("R12", "reached phase 3", int'(phase), 3);
      release_reset();
      cyc(INIT - 2);
      chk("R12", "timer restarted", int'(phase), 1);
      cyc(3);
      // R5: error wins over done in phase 2, parity stays off
      cur_req = "R5";
      step_done = 3'b001; phase_err = 4'b0001; cyc(); step_done = '0; phase_err = '0; cyc();
      chk("R5", "error priority", int'(phase), 7);
      chk("R11", "par off after phase 2 fault", int'(par_mon_en), 0);
      cur_req = "R6";
      pulse_sync();
      cyc(2);
      report();
      $finish;
   end
endmodule